// File: doc/BRIEF.md
# Early Receive Interrupt Generator

This block watches an Ethernet frame byte by byte while it arrives and warns the host before the frame is complete. Software programs an 8-bit threshold in units of 8-byte quadwords. The block reads the frame's Type/Length field and from then on tracks how many quadwords of the frame are still outstanding. When that count matches the threshold, the block sets a sticky status bit and raises a level interrupt. Receive software can then start preparing buffers before the end-of-frame arrives.

The remaining count is taken only from the length that the frame declares. It does not depend on any FIFO level or on how many bytes have been stored so far. The header is 14 bytes: destination, source, then the Type/Length field. The count is therefore (14 + declared length − bytes accepted), rounded up to whole quadwords. A field value of 1536 or more is an EtherType, not a length, so such frames never trigger. MAC framing, CRC checking, DMA and the host bus sit outside this block.

Top module: `erly_rx_irq`

## Requirements
- R1: After reset the threshold reads 00h, and both the status bit and the interrupt are 0.
- R2: A cycle with `thr_we` high loads `thr_wdata` into the threshold, and `thr_rd` shows the new value from the next cycle on.
- R3: While the threshold is 00h, no frame ever sets the status bit.
- R4: The byte accepted with `sof` is index 0. Bytes 12 (upper 8 bits) and 13 (lower 8 bits) form the Type/Length value L. After accepting byte i (i ≥ 13), the remaining byte count is max(0, 14 + L − (i+1)). The remaining quadword count is that byte count divided by 8, rounded up. The first accepted byte that makes this count equal the non-zero threshold sets the status bit on the following clock edge.
- R5: A frame whose Type/Length value is 1536 or more produces no event. A value of 1535 is still treated as a length.
- R6: A frame sets the status bit at most once, even while the quadword count stays equal to the threshold over several bytes. The next accepted `sof` re-arms the trigger.
- R7: The status bit stays set until a cycle with `clr_early` high clears it. If a new event and a clear fall on the same edge, the bit stays set.
- R8: `irq` equals the status bit in every cycle.
- R9: A frame that ends before its quadword count reaches the threshold produces no event. This covers a threshold above the starting count and an early `eof`.
- R10: Only cycles with `byte_vld` high advance the frame. Idle cycles, and valid bytes that arrive after `eof` without a new `sof`, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| sof | input | 1 | The present byte is the first of a frame |
| eof | input | 1 | The present byte is the last of a frame |
| rx_byte | input | 8 | Received byte |
| thr_we | input | 1 | Write strobe for the threshold |
| thr_wdata | input | 8 | Threshold value to write |
| thr_rd | output | 8 | Current threshold |
| clr_early | input | 1 | Write-one-to-clear strobe for the status bit |
| early_sts | output | 1 | Sticky early-receive status |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is the single-fire guard. The quadword count stays equal to the threshold for up to eight consecutive bytes, so a missing guard only shows if software clears the status inside that window. The bench clears the bit a few bytes after the event while the count still matches, and then expects the bit to stay clear. A second directed frame places the clear on the exact edge where the event is recorded, to check that the set wins over the clear. A third frame arrives after the guarded one and must fire again, which checks the re-arm on `sof`.

// File: rtl/erly_pkg.sv
// Shared constants for the early receive interrupt generator.
// Assumes untagged Ethernet framing: 6-byte destination, 6-byte source,
// then the 2-byte Type/Length field sent most significant byte first.
package erly_pkg;
    localparam int HDR_BYTES = 14;    // bytes up to and including Type/Length
    localparam int ETYPE_MIN = 1536;  // smallest value read as an EtherType
    localparam int QW_BYTES  = 8;     // bytes per quadword
    localparam int TL_W      = 16;    // width of the Type/Length field
endpackage

// File: rtl/erly_len_track.sv
// Frame length tracker. It follows the byte position of the current frame,
// captures the Type/Length field, and from then on keeps the count of bytes
// the frame still owes, presented as a quadword count rounded up.
// Assumes: sof and eof qualify only with byte_vld; bytes outside a frame are
// dropped; a length of 1536 or more marks the frame ineligible.
module erly_len_track #(
    parameter int HDR   = erly_pkg::HDR_BYTES,
    parameter int ETMIN = erly_pkg::ETYPE_MIN,
    parameter int QW    = erly_pkg::QW_BYTES,
    parameter int TL_W  = erly_pkg::TL_W,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             sof,
    input  logic             eof,
    input  logic [7:0]       rx_byte,
    output logic             upd,      // rem_qw was refreshed by the last byte
    output logic             elig,     // current frame carries a usable length
    output logic [THR_W-1:0] rem_qw,   // quadwords still to be received
    output logic             sof_acc   // a frame start is accepted this cycle
);
    localparam int HCNT_W = $clog2(HDR + 1);
    localparam int QW_SH  = $clog2(QW);

    logic              in_frame;
    logic [HCNT_W-1:0] hcnt;
    logic [HCNT_W-1:0] idx;
    logic [7:0]        tl_hi;
    logic [TL_W-1:0]   rem_b;
    logic [TL_W-1:0]   tl_val;
    logic [TL_W:0]     rem_sum;
    logic              accept;

    assign sof_acc = byte_vld && sof;
    assign accept  = byte_vld && (sof || in_frame);
    assign idx     = sof_acc ? '0 : hcnt;
    assign tl_val  = {tl_hi, rx_byte};

    // Frame-active flag: opens on an accepted sof, closes after eof.
    always_ff @(posedge clk) begin
        if (!rst_n)                in_frame <= 1'b0;
        else if (accept && eof)    in_frame <= 1'b0;
        else if (sof_acc)          in_frame <= 1'b1;
    end

    // Header byte position, saturating once the header is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   hcnt <= '0;
        else if (sof_acc)                             hcnt <= HCNT_W'(1);
        else if (accept && hcnt != HCNT_W'(HDR))      hcnt <= hcnt + 1'b1;
    end

    // Holds the upper byte of Type/Length until the lower byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   tl_hi <= '0;
        else if (accept && idx == HCNT_W'(HDR - 2))   tl_hi <= rx_byte;
    end

    // Remaining-byte counter, eligibility and refresh strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_b <= '0;
            elig  <= 1'b0;
            upd   <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (accept && idx == HCNT_W'(HDR - 1)) begin
                rem_b <= tl_val;
                elig  <= (tl_val < TL_W'(ETMIN));
                upd   <= 1'b1;
            end else if (accept && idx == HCNT_W'(HDR)) begin
                rem_b <= (rem_b == '0) ? '0 : rem_b - 1'b1;
                upd   <= 1'b1;
            end else if (sof_acc) begin
                elig  <= 1'b0;
            end
        end
    end

    // Round the byte count up to whole quadwords.
    assign rem_sum = {1'b0, rem_b} + (TL_W + 1)'(QW - 1);
    assign rem_qw  = THR_W'(rem_sum >> QW_SH);
endmodule

// File: rtl/erly_trigger.sv
// Compares the remaining quadword count with the threshold and fires at most
// once per frame. Assumes upd pulses for one cycle after each counted byte
// and that an accepted sof starts a new frame.
module erly_trigger #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             elig,
    input  logic [THR_W-1:0] rem_qw,
    input  logic             sof_acc,
    input  logic [THR_W-1:0] thr,
    output logic             fire
);
    logic fired;

    assign fire = upd && elig && (thr != '0) && (rem_qw == thr) && !fired;

    // Once-per-frame latch, re-armed by the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)       fired <= 1'b0;
        else if (sof_acc) fired <= 1'b0;
        else if (fire)    fired <= 1'b1;
    end
endmodule

// File: rtl/erly_csr.sv
// Software-visible state: the threshold register and the sticky status bit.
// A new event takes priority over a clear that lands on the same edge.
module erly_csr #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             clr_early,
    input  logic             fire,
    output logic [THR_W-1:0] thr_q,
    output logic             early_sts
);
    // Threshold register, zero (disabled) out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= '0;
        else if (thr_we) thr_q <= thr_wdata;
    end

    // Sticky status: set by an event, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)         early_sts <= 1'b0;
        else if (fire)      early_sts <= 1'b1;
        else if (clr_early) early_sts <= 1'b0;
    end
endmodule

// File: rtl/erly_rx_irq.sv
// Top of the early receive interrupt generator. It ties the length tracker,
// the once-per-frame trigger and the register pair together. The interrupt
// line is a level copy of the sticky status bit.
module erly_rx_irq #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             sof,
    input  logic             eof,
    input  logic [7:0]       rx_byte,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    output logic [THR_W-1:0] thr_rd,
    input  logic             clr_early,
    output logic             early_sts,
    output logic             irq
);
    logic             upd_w;
    logic             elig_w;
    logic             sof_acc_w;
    logic             fire_w;
    logic [THR_W-1:0] rem_qw_w;

    erly_len_track #(.THR_W(THR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
        .rx_byte(rx_byte), .upd(upd_w), .elig(elig_w), .rem_qw(rem_qw_w),
        .sof_acc(sof_acc_w)
    );

    erly_trigger #(.THR_W(THR_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .upd(upd_w), .elig(elig_w), .rem_qw(rem_qw_w),
        .sof_acc(sof_acc_w), .thr(thr_rd), .fire(fire_w)
    );

    erly_csr #(.THR_W(THR_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .clr_early(clr_early), .fire(fire_w), .thr_q(thr_rd),
        .early_sts(early_sts)
    );

    assign irq = early_sts;
endmodule

// File: rtl/erly_rx_irq_chk.sv
// Property checker for erly_rx_irq, attached by bind below.
module erly_rx_irq_chk #(
    parameter int THR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             thr_we,
    input logic [THR_W-1:0] thr_wdata,
    input logic [THR_W-1:0] thr_rd,
    input logic             clr_early,
    input logic             early_sts,
    input logic             fire
);
    // R2
    thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> (thr_rd == $past(thr_wdata)));

    // R3
    zero_thr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early_sts) |-> ($past(thr_rd) != '0));

    // R6
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (early_sts && !clr_early) |=> early_sts);

    // R7
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (early_sts && clr_early && !fire) |=> !early_sts);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> early_sts);
endmodule

bind erly_rx_irq erly_rx_irq_chk #(.THR_W(THR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .thr_rd(thr_rd), .clr_early(clr_early), .early_sts(early_sts),
    .fire(fire_w)
);

// File: tb/test_erly_rx_irq.sv
// Directed bench for erly_rx_irq: one task per scenario.
module test_erly_rx_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0, sof = 1'b0, eof = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wdata = '0;
    logic [7:0] thr_rd;
    logic       clr_early = 1'b0;
    logic       early_sts, irq;

    int n_chk = 0;
    int n_err = 0;
    int irq_mis = 0;

    always #5 clk = ~clk;

    erly_rx_irq i_erly_rx_irq (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
        .rx_byte(rx_byte), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .thr_rd(thr_rd), .clr_early(clr_early), .early_sts(early_sts), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of the trigger point: index of the firing byte, or -1.
    function automatic int exp_fire(input int tl, input int nbytes, input int thr);
        if (thr == 0 || tl >= 1536) return -1;
        for (int i = 13; i < nbytes; i++) begin
            int rem = 14 + tl - (i + 1);
            if (rem < 0) rem = 0;
            if ((rem + 7) / 8 == thr) return i;
        end
        return -1;
    endfunction

    task automatic set_thr(input int v);
        @(negedge clk); thr_we = 1'b1; thr_wdata = 8'(v);
        @(negedge clk); thr_we = 1'b0;
    endtask

    task automatic clear_sts();
        @(negedge clk); clr_early = 1'b1;
        @(negedge clk); clr_early = 1'b0;
    endtask

    // Streams one frame. With gaps, every other cycle carries junk and no
    // valid. seen is the first sampling cycle with status high (-1 if none);
    // fin is the status three cycles after the last byte.
    task automatic run_frame(input int tl, input int nbytes, input bit gaps,
                             input int clr_at, output int seen, output bit fin);
        int b = 0;
        int c = 0;
        int tail = 0;
        seen = -1;
        while (tail < 4) begin
            @(negedge clk);
            if (irq !== early_sts) irq_mis++;
            if (seen < 0 && early_sts) seen = c;
            byte_vld = 1'b0; sof = 1'b0; eof = 1'b0; clr_early = 1'b0;
            rx_byte = 8'(c * 7 + 3);
            if (b < nbytes && !(gaps && c[0])) begin
                byte_vld = 1'b1;
                sof = (b == 0);
                eof = (b == nbytes - 1);
                if (b == 12)      rx_byte = 8'(tl >> 8);
                else if (b == 13) rx_byte = 8'(tl);
                else              rx_byte = 8'(b * 3 + 1);
                if (b == clr_at) clr_early = 1'b1;
                b++;
            end else if (b >= nbytes) begin
                tail++;
            end
            c++;
        end
        fin = early_sts;
        byte_vld = 1'b0; sof = 1'b0; eof = 1'b0; clr_early = 1'b0;
    endtask

    task automatic t_reset();
        check(thr_rd == 8'h00, "R1 threshold", thr_rd, 0);
        check(early_sts == 1'b0, "R1 status", early_sts, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_thr_rw();
        set_thr(8'h5A);
        check(thr_rd == 8'h5A, "R2 readback", thr_rd, 8'h5A);
        set_thr(8'hC3);
        check(thr_rd == 8'hC3, "R2 readback", thr_rd, 8'hC3);
    endtask

    task automatic t_disabled();
        int s; bit f;
        set_thr(0); clear_sts();
        run_frame(100, 118, 1'b0, -1, s, f);
        check(s == -1 && !f, "R3 zero threshold", s, -1);
    endtask

    task automatic expect_fire(input int tl, input int nb, input int thr, input string req);
        int s; bit f; int e;
        set_thr(thr); clear_sts();
        e = exp_fire(tl, nb, thr);
        run_frame(tl, nb, 1'b0, -1, s, f);
        check(((s < 0) ? -1 : s - 2) == e, req, (s < 0) ? -1 : s - 2, e);
        check(f == (e >= 0), req, f, (e >= 0));
    endtask

    task automatic t_fire_pos();
        expect_fire(100, 118, 3, "R4 mid frame");
        expect_fire(100, 118, 13, "R4 first count");
        expect_fire(40, 60, 1, "R4 last quadword");
        check(irq_mis == 0, "R8 irq follows status", irq_mis, 0);
    endtask

    task automatic t_etype();
        expect_fire(16'h0800, 60, 1, "R5 ethertype");
        expect_fire(1535, 20, 192, "R5 largest length");
        expect_fire(1536, 20, 192, "R5 smallest type");
    endtask

    task automatic t_once();
        int s; bit f;
        set_thr(3); clear_sts();
        run_frame(100, 118, 1'b0, 92, s, f);
        check(s - 2 == 89, "R6 fired first", s - 2, 89);
        check(!f, "R6 no refire in window", f, 0);
        run_frame(100, 118, 1'b0, -1, s, f);
        check(s - 2 == 89 && f, "R6 rearm next frame", s - 2, 89);
    endtask

    task automatic t_sticky();
        int s; bit f;
        set_thr(3); clear_sts();
        run_frame(100, 118, 1'b0, 90, s, f);
        check(f, "R7 set beats clear", f, 1);
        repeat (5) @(negedge clk);
        check(early_sts, "R7 sticky", early_sts, 1);
        clear_sts();
        check(!early_sts && !irq, "R7 cleared", early_sts, 0);
    endtask

    task automatic t_short();
        int s; bit f;
        set_thr(3); clear_sts();
        run_frame(100, 50, 1'b0, -1, s, f);
        check(s == -1 && !f, "R9 early eof", s, -1);
        set_thr(14); clear_sts();
        run_frame(100, 118, 1'b0, -1, s, f);
        check(s == -1 && !f, "R9 threshold above start", s, -1);
    endtask

    task automatic t_gaps();
        int s; bit f;
        set_thr(3); clear_sts();
        run_frame(40, 60, 1'b1, -1, s, f);
        check(f, "R10 gapped frame fires", f, 1);
        clear_sts();
        run_frame(40, 29, 1'b1, -1, s, f);
        check(!f, "R10 idle cycles do not advance", f, 0);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); byte_vld = 1'b1; rx_byte = 8'(k);
        end
        @(negedge clk); byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(!early_sts, "R10 bytes outside frame", early_sts, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_thr_rw();
        t_disabled();
        t_fire_pos();
        t_etype();
        t_once();
        t_sticky();
        t_short();
        t_gaps();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule